// File: doc/BRIEF.md
# Mode-Programmed SDRAM Burst Engine

This block models the burst machinery inside a low-power synchronous DRAM as the device itself sees it. It holds a mode word that the controller writes over the address lines. That word sets four things: how many columns each access covers, whether the columns advance in linear or XOR-scrambled order, how many clocks pass between a read command and its first data word, and whether writes are single-word. Each read or write command carries a starting column. From that point the engine produces one column address per clock in the programmed order. Write beats store the data word presented in the same cycle. Read beats fetch from a 256-column internal store and pass through a latency pipeline that drives a data-valid strobe and a bus-drive enable.

Commands arrive on a 3-bit code, one per clock. A new read or write cancels the burst in progress. A terminate command stops the burst. Read words already in flight still leave the pipeline in order. If the controller writes a mode word with a reserved setting, the engine raises an error flag and refuses accesses until a legal word is loaded.

Top module: `sdr_burst_engine`

## Requirements
- R1: Command codes on `cmd` are 0 idle, 1 load-mode, 2 read, 3 write, 4 terminate. A load-mode with `ba` = 0 takes its mode word from `addr` as follows: [2:0] length code, [3] order (0 linear, 1 interleaved), [6:4] latency, [8:7] operating mode (must be 00), [9] write mode. Address bits 10 and up have no effect.
- R2: A load-mode with `ba` not equal to 0 leaves both the mode and the error flag unchanged.
- R3: Length codes 0, 1, 2 and 3 give bursts of 1, 2, 4 and 8 beats. Beat i of a burst appears on `beat_valid`/`beat_col` in the i-th cycle after the command cycle, and beat 0 appears in the command cycle itself.
- R4: For a burst of L beats, columns stay inside the L-aligned block that holds the start column. In linear order the low bits of beat i are (start + i) mod L. In interleaved order they are start XOR i.
- R5: Length code 7 with linear order gives a full-page burst. It steps through columns modulo 256, wraps from 255 to 0, and runs until a terminate or a new access.
- R6: Read data for a read registered at edge n with latency m (1 to 3) appears on `rdata` with `rd_valid` high after edge n+m. It then delivers one stored word per beat, in beat order.
- R7: `dq_oe` rises one cycle before the first `rd_valid` of a read and stays high in every cycle that `rd_valid` is high.
- R8: With write-mode bit 1, each write stores a single column. Reads still use the programmed length.
- R9: A load-mode with a reserved length code (4 to 6, or 7 with interleaved order), a latency code outside 1 to 3, or a nonzero operating mode sets `mode_err`. The previous settings are kept. While `mode_err` is high, reads and writes produce no beats. A legal load clears the flag.
- R10: A read or write issued during a burst starts a new sequence at its own column in that same cycle. Read words of the old burst already in the latency pipeline still come out, ahead of the new ones.
- R11: A terminate command produces no beat in its cycle and ends the burst.
- R12: After reset `rd_valid`, `dq_oe`, `beat_valid` and `mode_err` are 0. The mode is single-beat, linear order, latency 2, write bursts enabled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd | input | 3 | Command code for this cycle |
| ba | input | 2 | Bank select, qualifies load-mode |
| addr | input | ADDR_W | Mode word or starting column |
| wdata | input | DQ_W | Write data for the current write beat |
| rdata | output | DQ_W | Read data |
| rd_valid | output | 1 | Read data valid |
| dq_oe | output | 1 | Data bus drive enable |
| mode_err | output | 1 | Reserved mode loaded |
| beat_valid | output | 1 | A burst beat occurs this cycle |
| beat_col | output | COL_W | Column of the current beat |

## Verification
Every cycle, the assertions check these properties: the drive enable covers and leads the valid strobe, a terminate never yields a beat, the error flag blocks new bursts, the beat counter stays within the burst length, and load-modes with a nonzero bank select or set high bits behave as required. The beat orders for each length and order, the latency alignment of the data words, page wraparound, single-word writes, and words from an aborted read draining ahead of the new ones can only be shown by the bench. It does this by comparing the column stream and the returned words against a column model of its own.

// File: rtl/sdr_burst_pkg.sv
package sdr_burst_pkg;

   typedef enum logic [2:0] {
      CMD_NOP   = 3'd0,
      CMD_MRS   = 3'd1,
      CMD_READ  = 3'd2,
      CMD_WRITE = 3'd3,
      CMD_BTERM = 3'd4
   } cmd_e;

   typedef struct packed {
      logic       wb_single;
      logic [1:0] cl;
      logic       inter;
      logic       full;
      logic [1:0] len_log2;
   } mode_t;

   localparam mode_t MODE_RESET = '{wb_single: 1'b0, cl: 2'd2, inter: 1'b0,
                                    full: 1'b0, len_log2: 2'd0};

   // True when a 10-bit mode word holds only supported codes.
   function automatic logic mode_legal(input logic [9:0] w);
      logic len_ok;
      logic lat_ok;
      len_ok = (w[2:0] <= 3'd3) || ((w[2:0] == 3'd7) && !w[3]);
      lat_ok = (w[6:4] >= 3'd1) && (w[6:4] <= 3'd3);
      return len_ok && lat_ok && (w[8:7] == 2'b00);
   endfunction

   function automatic mode_t mode_decode(input logic [9:0] w);
      mode_t m;
      m.wb_single = w[9];
      m.cl        = w[5:4];
      m.inter     = w[3];
      m.full      = (w[2:0] == 3'd7);
      m.len_log2  = w[1:0];
      return m;
   endfunction

endpackage

// File: rtl/sdr_mode_reg.sv
module sdr_mode_reg
   import sdr_burst_pkg::*;
#(
   parameter int ADDR_W = 12
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   output mode_t             mode_q,
   output logic              err_q
);

   logic load;
   logic legal;

   assign load  = (cmd == CMD_MRS) && (ba == 2'b00);
   assign legal = mode_legal(addr[9:0]);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         mode_q <= MODE_RESET;
         err_q  <= 1'b0;
      end else if (load) begin
         err_q <= !legal;
         if (legal) mode_q <= mode_decode(addr[9:0]);
      end
   end

   // R2: nonzero bank select leaves the mode untouched
   a_r2_bank_guard: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_MRS && ba != 2'b00) |=> ($stable(mode_q) && $stable(err_q)));

   // R1: high address bits do not turn a legal word into an error
   a_r1_high_bits_ignored: assert property (@(posedge clk) disable iff (!rst_n)
      (load && legal && addr[ADDR_W-1:10] != '0) |=> !err_q);

endmodule

// File: rtl/sdr_burst_seq.sv
module sdr_burst_seq
   import sdr_burst_pkg::*;
#(
   parameter int COL_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [2:0]       cmd,
   input  logic [COL_W-1:0] col,
   input  mode_t            mode,
   input  logic             err,
   output logic             beat_v,
   output logic             beat_rd,
   output logic [COL_W-1:0] beat_col
);

   localparam logic [COL_W-1:0] ONE = COL_W'(1);

   logic             act_q, rd_q, inter_q, full_q;
   logic [COL_W-1:0] mask_q, base_q, idx_q;

   logic             start, is_rd, single, n_full, cont, last;
   logic [COL_W-1:0] n_mask, offs, st_col;

   assign is_rd  = (cmd == CMD_READ);
   assign start  = (is_rd || cmd == CMD_WRITE) && !err;
   assign single = !is_rd && mode.wb_single;
   assign n_full = mode.full && !single;

   always_comb begin
      if (n_full)      n_mask = '1;
      else if (single) n_mask = '0;
      else             n_mask = (ONE << mode.len_log2) - ONE;
   end

   assign offs   = inter_q ? (base_q ^ idx_q) : (base_q + idx_q);
   assign st_col = (base_q & ~mask_q) | (offs & mask_q);
   assign cont   = act_q && !start && (cmd != CMD_BTERM);
   assign last   = !full_q && (idx_q == mask_q);

   assign beat_v   = start || cont;
   assign beat_rd  = start ? is_rd : rd_q;
   assign beat_col = start ? col : st_col;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         act_q   <= 1'b0;
         rd_q    <= 1'b0;
         inter_q <= 1'b0;
         full_q  <= 1'b0;
         mask_q  <= '0;
         base_q  <= '0;
         idx_q   <= '0;
      end else if (start) begin
         act_q   <= n_full || (n_mask != '0);
         rd_q    <= is_rd;
         inter_q <= mode.inter;
         full_q  <= n_full;
         mask_q  <= n_mask;
         base_q  <= col;
         idx_q   <= ONE;
      end else if (cont) begin
         idx_q <= idx_q + ONE;
         if (last) act_q <= 1'b0;
      end else if (cmd == CMD_BTERM) begin
         act_q <= 1'b0;
      end
   end

   // R11: terminate cycle carries no beat
   a_r11_bterm_no_beat: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd == CMD_BTERM) |-> !beat_v);

   // R9: error flag blocks new bursts
   a_r9_err_blocks: assert property (@(posedge clk) disable iff (!rst_n)
      (err && !act_q) |-> !beat_v);

   // R3: beat index never passes the burst length
   a_r3_idx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && !full_q) |-> (idx_q <= mask_q));

   // R5: full-page burst keeps running on idle cycles
   a_r5_full_runs: assert property (@(posedge clk) disable iff (!rst_n)
      (act_q && full_q && cmd == CMD_NOP) |=> act_q);

endmodule

// File: rtl/sdr_col_mem.sv
module sdr_col_mem #(
   parameter int COL_W = 8,
   parameter int DQ_W  = 16
) (
   input  logic             clk,
   input  logic             we,
   input  logic [COL_W-1:0] col,
   input  logic [DQ_W-1:0]  wdata,
   output logic [DQ_W-1:0]  rdata
);

   localparam int DEPTH = 1 << COL_W;

   logic [DQ_W-1:0] store [DEPTH];

   always_ff @(posedge clk) begin
      if (we) store[col] <= wdata;
   end

   assign rdata = store[col];

endmodule

// File: rtl/sdr_cas_pipe.sv
module sdr_cas_pipe #(
   parameter int DQ_W   = 16,
   parameter int MAX_CL = 3
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            v_in,
   input  logic [DQ_W-1:0] d_in,
   input  logic [1:0]      cl,
   output logic [DQ_W-1:0] d_out,
   output logic            v_out,
   output logic            oe
);

   localparam int STAGES = MAX_CL + 1;
   localparam int SEL_W  = $clog2(STAGES + 1);

   logic [STAGES:1]           v_vec;
   logic [STAGES:1][DQ_W-1:0] d_vec;
   logic [SEL_W-1:0]          sel_lat, sel_dat;

   for (genvar g = 1; g <= STAGES; g++) begin : g_stage
      logic            v;
      logic [DQ_W-1:0] d;
      if (g == 1) begin : g_head
         always_ff @(posedge clk) begin
            if (!rst_n) v <= 1'b0;
            else        v <= v_in;
            d <= d_in;
         end
      end else begin : g_tail
         always_ff @(posedge clk) begin
            if (!rst_n) v <= 1'b0;
            else        v <= v_vec[g-1];
            d <= d_vec[g-1];
         end
      end
      assign v_vec[g] = v;
      assign d_vec[g] = d;
   end

   assign sel_lat = SEL_W'(cl);
   assign sel_dat = sel_lat + SEL_W'(1);

   assign d_out = d_vec[sel_dat];
   assign v_out = v_vec[sel_dat];
   assign oe    = v_vec[sel_dat] | v_vec[sel_lat];

endmodule

// File: rtl/sdr_burst_engine.sv
module sdr_burst_engine
   import sdr_burst_pkg::*;
#(
   parameter int COL_W  = 8,
   parameter int DQ_W   = 16,
   parameter int ADDR_W = 12,
   parameter int MAX_CL = 3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [2:0]        cmd,
   input  logic [1:0]        ba,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DQ_W-1:0]   wdata,
   output logic [DQ_W-1:0]   rdata,
   output logic              rd_valid,
   output logic              dq_oe,
   output logic              mode_err,
   output logic              beat_valid,
   output logic [COL_W-1:0]  beat_col
);

   if (ADDR_W < 11) begin : g_bad_addr
      $error("ADDR_W must cover the mode word plus at least one spare bit");
   end
   if (COL_W < 3 || COL_W > ADDR_W) begin : g_bad_col
      $error("COL_W must be between 3 and ADDR_W");
   end
   if (MAX_CL != 3) begin : g_bad_cl
      $error("MAX_CL must match the 2-bit latency field");
   end

   mode_t           mode;
   logic            beat_rd;
   logic [DQ_W-1:0] mem_q;

   sdr_mode_reg #(.ADDR_W(ADDR_W)) u_mode (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .addr(addr),
      .mode_q(mode), .err_q(mode_err)
   );

   sdr_burst_seq #(.COL_W(COL_W)) u_seq (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .col(addr[COL_W-1:0]),
      .mode(mode), .err(mode_err),
      .beat_v(beat_valid), .beat_rd(beat_rd), .beat_col(beat_col)
   );

   sdr_col_mem #(.COL_W(COL_W), .DQ_W(DQ_W)) u_mem (
      .clk(clk), .we(beat_valid && !beat_rd), .col(beat_col),
      .wdata(wdata), .rdata(mem_q)
   );

   sdr_cas_pipe #(.DQ_W(DQ_W), .MAX_CL(MAX_CL)) u_pipe (
      .clk(clk), .rst_n(rst_n), .v_in(beat_valid && beat_rd), .d_in(mem_q),
      .cl(mode.cl), .d_out(rdata), .v_out(rd_valid), .oe(dq_oe)
   );

   // R7: drive enable covers every valid word
   a_r7_oe_covers: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> dq_oe);

   // R7: drive enable leads the first valid word
   a_r7_oe_leads: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(rd_valid) |-> $past(dq_oe));

endmodule

// File: tb/tb_sdr_burst_engine.sv
`timescale 1ns/1ps
module tb_sdr_burst_engine;

   localparam int COL_W = 8;
   localparam int DQ_W  = 16;
   localparam int ADDR_W = 12;
   localparam int NP = 40;

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [2:0]        cmd = 3'd0;
   logic [1:0]        ba = 2'd0;
   logic [ADDR_W-1:0] addr = '0;
   logic [DQ_W-1:0]   wdata = '0;
   logic [DQ_W-1:0]   rdata;
   logic              rd_valid, dq_oe, mode_err, beat_valid;
   logic [COL_W-1:0]  beat_col;

   always #4 clk = ~clk;

   sdr_burst_engine #(.COL_W(COL_W), .DQ_W(DQ_W), .ADDR_W(ADDR_W), .MAX_CL(3)) dut (
      .clk(clk), .rst_n(rst_n), .cmd(cmd), .ba(ba), .addr(addr), .wdata(wdata),
      .rdata(rdata), .rd_valid(rd_valid), .dq_oe(dq_oe), .mode_err(mode_err),
      .beat_valid(beat_valid), .beat_col(beat_col)
   );

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   logic [DQ_W-1:0] model [256];

   // Play buffers: per drive slot t and per output sample k
   logic [2:0]      p_cmd [NP];
   logic [7:0]      p_col [NP];
   logic [DQ_W-1:0] p_wd  [NP];
   logic            p_ebv [NP];
   logic [7:0]      p_ecol[NP];
   logic            p_ev  [NP];
   logic [DQ_W-1:0] p_ed  [NP];
   logic            p_eoe [NP];

   // Vector table: [15:13] length code, [12] order, [11:10] latency, [7:0] start
   localparam logic [15:0] VEC [8] = '{
      {3'd1, 1'b0, 2'd1, 2'b0, 8'h05},
      {3'd2, 1'b0, 2'd2, 2'b0, 8'h06},
      {3'd2, 1'b1, 2'd3, 2'b0, 8'h06},
      {3'd3, 1'b0, 2'd2, 2'b0, 8'h2D},
      {3'd3, 1'b1, 2'd1, 2'b0, 8'h2D},
      {3'd0, 1'b0, 2'd3, 2'b0, 8'h80},
      {3'd3, 1'b1, 2'd3, 2'b0, 8'hF3},
      {3'd1, 1'b1, 2'd2, 2'b0, 8'h11}
   };

   function automatic logic [DQ_W-1:0] pat(input int c);
      return {8'(c) ^ 8'h5A, 8'(c)};
   endfunction

   function automatic logic [ADDR_W-1:0] mw(input int bl, input int bt, input int cl, input int wb);
      return ADDR_W'({wb[0], 2'b00, cl[2:0], bt[0], bl[2:0]});
   endfunction

   function automatic logic [7:0] expcol(input int s, input int blc, input int bt, input int i);
      int m;
      int lo;
      if (blc == 7) return 8'((s + i) % 256);
      m  = (1 << blc) - 1;
      lo = bt ? ((s ^ i) & m) : ((s + i) & m);
      return 8'((s & ~m) | lo);
   endfunction

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic clear_play();
      for (int i = 0; i < NP; i++) begin
         p_cmd[i] = 3'd0; p_col[i] = '0; p_wd[i] = '0; p_ebv[i] = 1'b0;
         p_ecol[i] = '0; p_ev[i] = 1'b0; p_ed[i] = '0; p_eoe[i] = 1'b0;
      end
   endtask

   task automatic add_rd_beat(input int tb, input int c, input int cl);
      p_ebv[tb] = 1'b1; p_ecol[tb] = 8'(c);
      p_ev[tb+cl] = 1'b1; p_ed[tb+cl] = model[c];
      p_eoe[tb+cl-1] = 1'b1; p_eoe[tb+cl] = 1'b1;
   endtask

   task automatic play(input int nt, input string req);
      for (int t = 0; t <= nt; t++) begin
         @(negedge clk);
         cmd = p_cmd[t]; addr = ADDR_W'(p_col[t]); wdata = p_wd[t]; ba = 2'd0;
         #1;
         check(beat_valid == p_ebv[t], {req, " beat_valid"}, beat_valid, p_ebv[t]);
         if (p_ebv[t])
            check(beat_col == p_ecol[t], {req, " beat_col"}, beat_col, p_ecol[t]);
         if (t >= 1) begin
            check(rd_valid == p_ev[t-1], {req, " rd_valid"}, rd_valid, p_ev[t-1]);
            check(dq_oe == p_eoe[t-1], {req, " dq_oe"}, dq_oe, p_eoe[t-1]);
            if (p_ev[t-1])
               check(rdata == p_ed[t-1], {req, " rdata"}, rdata, p_ed[t-1]);
         end
      end
      @(negedge clk);
      cmd = 3'd0;
   endtask

   task automatic mrs(input logic [1:0] b, input logic [ADDR_W-1:0] w);
      @(negedge clk);
      cmd = 3'd1; ba = b; addr = w;
      @(negedge clk);
      cmd = 3'd0; ba = 2'd0;
      #1;
   endtask

   task automatic run_read(input int s, input int blc, input int bt, input int cl, input string req);
      int len;
      len = 1 << blc;
      clear_play();
      p_cmd[0] = 3'd2; p_col[0] = 8'(s);
      for (int i = 0; i < len; i++) add_rd_beat(i, expcol(s, blc, bt, i), cl);
      play(cl + len + 1, req);
   endtask

   initial begin : watchdog
      #(200000 * 8);
      if (!done) begin
         n_bad++;
         n_chk++;
         $display("FAIL watchdog actual=timeout expected=finish");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
         $finish;
      end
   end

   initial begin : main
      repeat (3) @(posedge clk);
      @(negedge clk);
      // R12: reset state
      check(rd_valid == 0 && dq_oe == 0 && mode_err == 0 && beat_valid == 0, "R12 reset outputs",
            {rd_valid, dq_oe, mode_err, beat_valid}, 0);
      rst_n = 1'b1;

      // R12: default mode is single beat, latency 2
      clear_play();
      p_cmd[0] = 3'd3; p_col[0] = 8'd3; p_wd[0] = 16'hBEEF; p_ebv[0] = 1'b1; p_ecol[0] = 8'd3;
      play(1, "R12 default write");
      model[3] = 16'hBEEF;
      run_read(3, 0, 0, 2, "R12 default read");

      // R5: fill the page with a full-page linear write burst
      mrs(2'd0, mw(7, 0, 1, 0));
      for (int i = 0; i < 256; i++) begin
         @(negedge clk);
         cmd = (i == 0) ? 3'd3 : 3'd0; addr = '0; wdata = pat(i);
         model[i] = pat(i);
         #1;
         check(beat_valid && beat_col == 8'(i), "R5 full-page write column", beat_col, i);
      end
      @(negedge clk);
      cmd = 3'd4;
      #1;
      check(beat_valid == 0, "R11 terminate ends write", beat_valid, 0);
      @(negedge clk);
      cmd = 3'd0;
      #1;
      check(beat_valid == 0, "R11 burst stays ended", beat_valid, 0);

      // R3 R4 R6 R7: table of lengths, orders, latencies and start columns
      for (int v = 0; v < 8; v++) begin
         mrs(2'd0, mw(int'(VEC[v][15:13]), int'(VEC[v][12]), int'(VEC[v][11:10]), 0));
         run_read(int'(VEC[v][7:0]), int'(VEC[v][15:13]), int'(VEC[v][12]),
                  int'(VEC[v][11:10]), "R3/R4/R6/R7 vector");
      end

      // R2: load with nonzero bank select ignored
      mrs(2'd0, mw(0, 0, 1, 0));
      mrs(2'd1, mw(0, 0, 3, 0));
      run_read(9, 0, 0, 1, "R2 bank guard");
      mrs(2'd2, mw(4, 0, 2, 0));
      check(mode_err == 0, "R2 bank guard error flag", mode_err, 0);

      // R1: high address bits ignored
      mrs(2'd0, mw(1, 0, 2, 0) | 12'hC00);
      check(mode_err == 0, "R1 high bits no error", mode_err, 0);
      run_read(4, 1, 0, 2, "R1 high bits mode applied");

      // R9: reserved codes flag an error and block accesses
      mrs(2'd0, mw(4, 0, 2, 0));
      check(mode_err == 1, "R9 reserved length", mode_err, 1);
      clear_play();
      p_cmd[0] = 3'd2; p_col[0] = 8'd0;
      play(5, "R9 read ignored");
      mrs(2'd0, mw(7, 1, 1, 0));
      check(mode_err == 1, "R9 interleaved full page", mode_err, 1);
      mrs(2'd0, mw(0, 0, 0, 0));
      check(mode_err == 1, "R9 reserved latency", mode_err, 1);
      mrs(2'd0, mw(0, 0, 1, 0) | 12'h080);
      check(mode_err == 1, "R9 nonzero operating mode", mode_err, 1);
      clear_play();
      p_cmd[0] = 3'd3; p_col[0] = 8'd7; p_wd[0] = 16'h0BAD;
      play(2, "R9 write ignored");
      mrs(2'd0, mw(1, 0, 2, 0));
      check(mode_err == 0, "R9 legal load clears", mode_err, 0);
      run_read(7, 1, 0, 2, "R9 blocked write left data and old settings kept");

      // R8: single-location writes, reads keep the burst length
      mrs(2'd0, mw(2, 0, 1, 1));
      clear_play();
      p_cmd[0] = 3'd3; p_col[0] = 8'd5; p_wd[0] = 16'h1234; p_ebv[0] = 1'b1; p_ecol[0] = 8'd5;
      play(2, "R8 single write");
      model[5] = 16'h1234;
      run_read(5, 2, 0, 1, "R8 read burst of four");

      // R10: abort mid-burst, old words drain first
      mrs(2'd0, mw(3, 0, 2, 0));
      clear_play();
      p_cmd[0] = 3'd2; p_col[0] = 8'h40;
      p_cmd[2] = 3'd2; p_col[2] = 8'h58;
      add_rd_beat(0, 8'h40, 2);
      add_rd_beat(1, 8'h41, 2);
      for (int i = 0; i < 8; i++) add_rd_beat(2 + i, 8'h58 + i, 2);
      play(14, "R10 abort restart");

      // R5 R11: full-page read wraps and stops on terminate
      mrs(2'd0, mw(7, 0, 1, 0));
      clear_play();
      p_cmd[0] = 3'd2; p_col[0] = 8'd250;
      for (int i = 0; i < 10; i++) add_rd_beat(i, (250 + i) % 256, 1);
      p_cmd[10] = 3'd4;
      play(15, "R5/R11 page wrap and terminate");

      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end

endmodule